// File: doc/BRIEF.md
# Radix-2^2 Trivial-Twiddle Butterfly Stage

This block is the second butterfly of a radix-2^2 single-path delay-feedback FFT pair. It takes one complex sample per accepted cycle from the first butterfly of the pair. It combines each sample with the one held `FB_DEPTH` samples earlier in a feedback delay line. Before that combination it may rotate the incoming sample by -j. The rotation swaps the real and imaginary parts and negates the new imaginary part, so no multiplier is needed. Because of this the pipeline needs non-trivial multipliers only where a radix-4 pipeline would, while every butterfly stays a plain two-input add/subtract.

Control comes from two bits of the FFT's shared sample counter.
- The stage's own bit chooses between the fill phase and the compute phase.
- The next higher bit, which belongs to the preceding stage, marks the half-frame that holds the odd twiddle exponent.

For the first pair of an N-point transform, `FB_DEPTH` is N/4. Later pairs use a quarter of the preceding pair's depth. The output feeds the non-trivial twiddle multiplier, which lies outside this block.

Top module: `r22_trivial_bf_stage`

## Requirements
- R1: While reset is held and on the first edge after it, `out_valid` is 0 and `out_re`/`out_im` are 0.
- R2: Fill phase (`cnt_own`=0). For an accepted sample, the output on the next cycle is the head of the feedback line, and the sample (after any rotation) enters the line.
- R3: Compute phase (`cnt_own`=1). For an accepted sample x', the output on the next cycle is H + x', where H is the head of the feedback line.
- R4: In the compute phase, H - x' enters the feedback line. It leaves the line as the output of the accepted sample `FB_DEPTH` positions later, which falls in the next fill phase.
- R5: When `cnt_own`=1 and `cnt_prev`=1, the incoming sample a+jb is replaced by b-ja before the butterfly. This adds no cycle.
- R6: For every other combination of `cnt_own` and `cnt_prev`, the sample enters the butterfly unchanged.
- R7: `out_valid` rises exactly one cycle after each accepted sample, except the first `FB_DEPTH` accepted samples after reset. Those only fill the line and produce no valid output.
- R8: A cycle with `in_valid`=0 changes no state. On the next cycle `out_valid` is 0 and `out_re`/`out_im` keep their previous values.
- R9: The output is `DATA_W`+2 bits wide, two's complement. Sums, differences and the negation of the most negative input are exact, with no wrap.
- R10: The sample counter must have value 0 on the first accepted sample after reset and advance by one per accepted sample. `cnt_own` is counter bit log2(`FB_DEPTH`) and `cnt_prev` is the bit above it. While the line is still filling, `cnt_own` must be 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample accepted this cycle |
| in_re | input | DATA_W | Real part of input, signed |
| in_im | input | DATA_W | Imaginary part of input, signed |
| cnt_own | input | 1 | Counter bit for this stage: 0 fill, 1 compute |
| cnt_prev | input | 1 | Counter bit of the preceding stage; selects the -j quarter |
| out_valid | output | 1 | Output sample valid |
| out_re | output | DATA_W+2 | Real part of output, signed |
| out_im | output | DATA_W+2 | Imaginary part of output, signed |

## Verification
A fault in the feedback line corrupts the fill-phase outputs that appear `FB_DEPTH` accepted samples after the faulty compute phase. A line entry that shifts during an idle cycle misaligns every later pairing, and the result is visible within one frame of 2·`FB_DEPTH` samples. A wrong rotation condition shows up in the very next compute output of the affected quarter, because its real and imaginary parts come out swapped or of the wrong sign. A fault in the priming count shows up at the ports within the first `FB_DEPTH`+1 accepted samples, as an output flagged valid too early or too late.

// File: rtl/r22_bf_pkg.sv
// Package: shared types for the radix-2^2 trivial-twiddle butterfly stage.
// Assumes: nothing beyond IEEE 1800-2017.
package r22_bf_pkg;

    // Phase of the delay-feedback butterfly, selected by the stage counter bit.
    typedef enum logic {
        PH_FILL    = 1'b0,
        PH_COMPUTE = 1'b1
    } bf_phase_e;

    // Phase decode from the stage's own counter bit.
    function automatic bf_phase_e phase_of(input logic own_bit);
        return own_bit ? PH_COMPUTE : PH_FILL;
    endfunction

endpackage

// File: rtl/neg_j_rotator.sv
// Module: neg_j_rotator
// Multiplies a complex sample by -j when rot_en is set: (a + jb) -> (b - ja).
// It only swaps and negates, so no multiplier is needed. The output is one bit
// wider so that negating the most negative input is exact.
// Assumes: purely combinational; the caller registers downstream.
module neg_j_rotator #(
    parameter int IN_W = 12,
    localparam int OUT_W = IN_W + 1
) (
    input  logic                    rot_en,
    input  logic signed [IN_W-1:0]  a_re,
    input  logic signed [IN_W-1:0]  a_im,
    output logic signed [OUT_W-1:0] y_re,
    output logic signed [OUT_W-1:0] y_im
);

    logic signed [OUT_W-1:0] ext_re;
    logic signed [OUT_W-1:0] ext_im;

    // Sign-extend, then swap and negate for the -j case.
    always_comb begin
        ext_re = OUT_W'(a_re);
        ext_im = OUT_W'(a_im);
        if (rot_en) begin
            y_re = ext_im;
            y_im = -ext_re;
        end else begin
            y_re = ext_re;
            y_im = ext_im;
        end
    end

    // R5 / R6: a rotation keeps the magnitude, and the bypass path is exact.
    always_comb begin
        if (rot_en) begin
            assert_rot_magnitude_R5: assert (
                (64'(y_re) * 64'(y_re) + 64'(y_im) * 64'(y_im)) ==
                (64'(a_re) * 64'(a_re) + 64'(a_im) * 64'(a_im)));
        end else begin
            assert_bypass_exact_R6: assert (y_re == OUT_W'(a_re) && y_im == OUT_W'(a_im));
        end
    end

endmodule

// File: rtl/fb_delay_line.sv
// Module: fb_delay_line
// Complex feedback shift register of DEPTH entries. It advances only when
// shift_en is set. The head is the entry pushed DEPTH shifts earlier.
// Assumes: DEPTH >= 1; all entries clear on synchronous active-low reset.
module fb_delay_line #(
    parameter int W     = 14,
    parameter int DEPTH = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                shift_en,
    input  logic signed [W-1:0] push_re,
    input  logic signed [W-1:0] push_im,
    output logic signed [W-1:0] head_re,
    output logic signed [W-1:0] head_im
);

    logic signed [W-1:0] tap_re [DEPTH];
    logic signed [W-1:0] tap_im [DEPTH];

    // The first tap takes the pushed value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tap_re[0] <= '0;
            tap_im[0] <= '0;
        end else if (shift_en) begin
            tap_re[0] <= push_re;
            tap_im[0] <= push_im;
        end
    end

    // Each later tap takes its predecessor on a shift.
    for (genvar k = 1; k < DEPTH; k++) begin : g_tap
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tap_re[k] <= '0;
                tap_im[k] <= '0;
            end else if (shift_en) begin
                tap_re[k] <= tap_re[k-1];
                tap_im[k] <= tap_im[k-1];
            end
        end
    end

    assign head_re = tap_re[DEPTH-1];
    assign head_im = tap_im[DEPTH-1];

    // R8: the head does not move on a cycle without a shift.
    assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> ($stable(head_re) && $stable(head_im)));

endmodule

// File: rtl/bf2_core.sv
// Module: bf2_core
// Combinational radix-2 delay-feedback butterfly.
//   Fill phase:    output = feedback head, push = incoming sample.
//   Compute phase: output = head + x, push = head - x.
// Assumes: x is already rotated and W is wide enough that head +/- x is exact.
module bf2_core
    import r22_bf_pkg::*;
#(
    parameter int X_W = 13,
    parameter int W   = 14
) (
    input  bf_phase_e           phase,
    input  logic signed [X_W-1:0] x_re,
    input  logic signed [X_W-1:0] x_im,
    input  logic signed [W-1:0] fb_re,
    input  logic signed [W-1:0] fb_im,
    output logic signed [W-1:0] y_re,
    output logic signed [W-1:0] y_im,
    output logic signed [W-1:0] push_re,
    output logic signed [W-1:0] push_im
);

    logic signed [W-1:0] xe_re;
    logic signed [W-1:0] xe_im;

    // Choose between the fill pass-through and the add/subtract pair.
    always_comb begin
        xe_re = W'(x_re);
        xe_im = W'(x_im);
        if (phase == PH_COMPUTE) begin
            y_re    = fb_re + xe_re;
            y_im    = fb_im + xe_im;
            push_re = fb_re - xe_re;
            push_im = fb_im - xe_im;
        end else begin
            y_re    = fb_re;
            y_im    = fb_im;
            push_re = xe_re;
            push_im = xe_im;
        end
    end

endmodule

// File: rtl/prime_tracker.sv
// Module: prime_tracker
// Counts accepted samples after reset up to DEPTH. Once it reaches DEPTH, the
// feedback line holds real data and outputs may be flagged valid.
// Assumes: the sample counter starts at zero on the first accepted sample.
module prime_tracker #(
    parameter int DEPTH = 4,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic cnt_own,
    output logic primed
);

    logic [CW-1:0] fill_cnt;

    // Saturating count of accepted samples since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fill_cnt <= '0;
        else if (in_valid && !primed)
            fill_cnt <= fill_cnt + CW'(1);
    end

    assign primed = (fill_cnt == CW'(DEPTH));

    // R10: the first DEPTH accepted samples must fall in a fill phase.
    assert_counter_aligned_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !primed) |-> !cnt_own);

    // R7: once primed, the stage stays primed until reset.
    assert_primed_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        primed |=> primed);

endmodule

// File: rtl/r22_trivial_bf_stage.sv
// Module: r22_trivial_bf_stage (top)
// Second butterfly of a radix-2^2 delay-feedback FFT pair. It rotates the
// incoming sample by -j in the odd-exponent quarter, runs a radix-2
// delay-feedback butterfly over an FB_DEPTH line, and registers the result.
// Latency is one cycle from accepted sample to output.
// Assumes: cnt_own and cnt_prev are bits log2(FB_DEPTH) and log2(FB_DEPTH)+1
// of a shared sample counter that is zero at the first accepted sample.
module r22_trivial_bf_stage
    import r22_bf_pkg::*;
#(
    parameter int DATA_W   = 12,
    parameter int FB_DEPTH = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_re,
    input  logic signed [DATA_W-1:0] in_im,
    input  logic                     cnt_own,
    input  logic                     cnt_prev,
    output logic                     out_valid,
    output logic signed [DATA_W+1:0] out_re,
    output logic signed [DATA_W+1:0] out_im
);

    localparam int ROT_W = DATA_W + 1;
    localparam int OUT_W = DATA_W + 2;

    logic                    rot_en;
    logic signed [ROT_W-1:0] x_re;
    logic signed [ROT_W-1:0] x_im;
    logic signed [OUT_W-1:0] head_re;
    logic signed [OUT_W-1:0] head_im;
    logic signed [OUT_W-1:0] bf_re;
    logic signed [OUT_W-1:0] bf_im;
    logic signed [OUT_W-1:0] push_re;
    logic signed [OUT_W-1:0] push_im;
    logic                    primed;
    bf_phase_e               phase;

    assign phase  = phase_of(cnt_own);
    assign rot_en = cnt_own & cnt_prev;

    neg_j_rotator #(.IN_W(DATA_W)) u_rot (
        .rot_en (rot_en),
        .a_re   (in_re),
        .a_im   (in_im),
        .y_re   (x_re),
        .y_im   (x_im)
    );

    bf2_core #(.X_W(ROT_W), .W(OUT_W)) u_core (
        .phase   (phase),
        .x_re    (x_re),
        .x_im    (x_im),
        .fb_re   (head_re),
        .fb_im   (head_im),
        .y_re    (bf_re),
        .y_im    (bf_im),
        .push_re (push_re),
        .push_im (push_im)
    );

    fb_delay_line #(.W(OUT_W), .DEPTH(FB_DEPTH)) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (in_valid),
        .push_re  (push_re),
        .push_im  (push_im),
        .head_re  (head_re),
        .head_im  (head_im)
    );

    prime_tracker #(.DEPTH(FB_DEPTH)) u_prime (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .cnt_own  (cnt_own),
        .primed   (primed)
    );

    // Output register: capture the butterfly result on each accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_re    <= '0;
            out_im    <= '0;
        end else begin
            out_valid <= in_valid && primed;
            if (in_valid) begin
                out_re <= bf_re;
                out_im <= bf_im;
            end
        end
    end

    // R8: an idle cycle gives no valid output on the next cycle.
    assert_idle_no_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R8: an idle cycle leaves the output data unchanged.
    assert_idle_hold_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_re) && $stable(out_im)));

    // R2: in the fill phase the output is the line head seen on the accepting edge.
    assert_fill_passes_head_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !cnt_own) |=> (out_re == $past(head_re) && out_im == $past(head_im)));

    // R7: a valid output is always preceded by an accepted sample.
    assert_valid_follows_input_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

endmodule

// File: tb/r22_trivial_bf_stage_tb.sv
module r22_trivial_bf_stage_tb;

    localparam int DW    = 12;
    localparam int L     = 4;
    localparam int LB    = 2;      // log2(L)
    localparam int MAXS  = 1024;
    localparam int WDOG  = 20000;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  in_valid = 1'b0;
    logic signed [DW-1:0]  in_re = '0;
    logic signed [DW-1:0]  in_im = '0;
    logic                  cnt_own = 1'b0;
    logic                  cnt_prev = 1'b0;
    logic                  out_valid;
    logic signed [DW+1:0]  out_re;
    logic signed [DW+1:0]  out_im;

    always #5 clk = ~clk;

    r22_trivial_bf_stage #(.DATA_W(DW), .FB_DEPTH(L)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_re(in_re), .in_im(in_im), .cnt_own(cnt_own), .cnt_prev(cnt_prev),
        .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
    );

    int total = 0;
    int bad = 0;
    int idx = 0;
    int xr [MAXS];
    int xi [MAXS];
    int q_re [$];
    int q_im [$];
    int q_tag [$];
    int last_re = 0;
    int last_im = 0;
    bit finished = 0;

    function automatic string tag_name(input int t);
        case (t)
            0: return "R2/R4 fill";
            1: return "R3/R6 compute";
            2: return "R3/R5 compute rotated";
            default: return "R9 extreme";
        endcase
    endfunction

    // Driver: present one accepted sample and push its expected output.
    task automatic drive(input int re, input int im, input bit extreme);
        int own, prv, p, er, ei, tg;
        @(negedge clk);
        own = (idx >> LB) & 1;
        prv = (idx >> (LB + 1)) & 1;
        in_valid = 1'b1;
        in_re    = DW'(re);
        in_im    = DW'(im);
        cnt_own  = own[0];
        cnt_prev = prv[0];
        if (own == 1 && prv == 1) begin
            xr[idx] = im;
            xi[idx] = -re;
        end else begin
            xr[idx] = re;
            xi[idx] = im;
        end
        p = idx % (2 * L);
        if (idx >= L) begin
            if (p >= L) begin
                er = xr[idx - L] + xr[idx];
                ei = xi[idx - L] + xi[idx];
                tg = (own == 1 && prv == 1) ? 2 : 1;
            end else begin
                er = xr[idx - 2*L] - xr[idx - L];
                ei = xi[idx - 2*L] - xi[idx - L];
                tg = 0;
            end
            if (extreme) tg = 3;
            q_re.push_back(er);
            q_im.push_back(ei);
            q_tag.push_back(tg);
        end
        idx++;
    endtask

    // Idle cycles. The cycles after the first one check R8 at the ports.
    task automatic idle(input int n);
        @(negedge clk);
        in_valid = 1'b0;
        cnt_own  = 1'b1;
        cnt_prev = 1'b1;
        in_re    = DW'(1234);
        for (int k = 1; k < n; k++) begin
            @(negedge clk);
            total++;
            if (out_valid !== 1'b0 || int'(out_re) != last_re || int'(out_im) != last_im) begin
                bad++;
                $display("FAIL R8 idle hold: valid=%0b re=%0d im=%0d expected valid=0 re=%0d im=%0d",
                         out_valid, out_re, out_im, last_re, last_im);
            end
        end
    endtask

    // Monitor: compare each valid output with the front of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && out_valid && !finished) begin
            total++;
            if (q_re.size() == 0) begin
                bad++;
                $display("FAIL R7 unexpected valid output re=%0d im=%0d expected none", out_re, out_im);
            end else begin
                int er, ei, tg;
                er = q_re.pop_front();
                ei = q_im.pop_front();
                tg = q_tag.pop_front();
                if (int'(out_re) != er || int'(out_im) != ei) begin
                    bad++;
                    $display("FAIL %s: actual re=%0d im=%0d expected re=%0d im=%0d",
                             tag_name(tg), out_re, out_im, er, ei);
                end
            end
            last_re = int'(out_re);
            last_im = int'(out_im);
        end
    end

    // Watchdog: a hung run counts as a failure and still reaches the summary.
    initial begin
        repeat (WDOG) @(posedge clk);
        if (!finished) begin
            finished = 1;
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state.
        repeat (3) @(negedge clk);
        total++;
        if (out_valid !== 1'b0 || out_re != 0 || out_im != 0) begin
            bad++;
            $display("FAIL R1 reset: valid=%0b re=%0d im=%0d expected valid=0 re=0 im=0",
                     out_valid, out_re, out_im);
        end
        rst_n = 1'b1;
        @(negedge clk);
        total++;
        if (out_valid !== 1'b0) begin
            bad++;
            $display("FAIL R1 after reset: valid=%0b expected 0", out_valid);
        end

        // R7: during priming nothing valid may appear.
        for (int i = 0; i < L; i++) begin
            drive(i + 1, -(i + 1), 0);
            @(posedge clk); #1;
            total++;
            if (out_valid !== 1'b0) begin
                bad++;
                $display("FAIL R7 priming: valid=%0b expected 0 at sample %0d", out_valid, i);
            end
        end

        // Ramp over several frames (R2, R3, R4, R5, R6).
        for (int i = 0; i < 4 * 4 * L - L; i++) drive(10 * i - 300, 7 * i + 5, 0);

        // Random values with gaps (R8 and realignment).
        for (int i = 0; i < 96; i++) begin
            drive(int'($urandom_range(0, 4095)) - 2048, int'($urandom_range(0, 4095)) - 2048, 0);
            if (i % 13 == 5) idle(3);
        end

        // Extremes: the most negative and most positive values (R9).
        for (int i = 0; i < 8 * L; i++) begin
            if (i % 2 == 0) drive(-2048, -2048, 1);
            else            drive(2047, -2048, 1);
        end
        for (int i = 0; i < 4 * L; i++) drive(-2048, 2047, 1);

        idle(4);

        // R7: every expected output must have appeared.
        total++;
        if (q_re.size() != 0) begin
            bad++;
            $display("FAIL R7 missing outputs: actual pending=%0d expected 0", q_re.size());
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule